// File: doc/BRIEF.md
# Floating-Point Register List Block-Move Sequencer

This block runs a multi-register transfer between an eight-entry floating-point register file and byte-addressed memory. The caller hands it a register selection mask, a transfer direction, a two-bit mask-source mode, a predecrement flag and an already computed base address. The mask comes either straight from the low byte of the command word or, in dynamic mode, from the low byte of a data register. The caller reads that data register, which command bits 6:4 select, and presents its value on `dyn_mask`. The sequencer then works out which registers take part, in what order they are visited and where each one lives in memory. It also returns the total number of bytes the transfer covers.

Every register holds an 80-bit extended value, 16 bits of sign and exponent above a 64-bit mantissa. In memory that value fills a 12-byte slot. The slot is moved as three 32-bit beats on a request/acknowledge port. A store writes the sign/exponent word in the upper half of the first beat and zero in the lower half, which is the pad word. A load throws the pad away and writes the reassembled value into the register file in one cycle.

Top module: `fmm_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `mem_req`, `mem_we` and `rf_we` are 0 and `xfer_size` is 0.
- R2: On a load (`store`=0), a `mode` of 0 or 1 is invalid. `err` then pulses for one cycle in the cycle after `start`, `xfer_size` becomes 0, `done` stays 0, and neither memory nor the register file is accessed.
- R3: The mask comes from `dyn_mask` for a load with `mode`=3 and for a store with `mode`=1 or 3. In every other accepted case it comes from `cmd_mask`, and the unused mask input has no effect.
- R4: In the cycle after an accepted valid `start`, `xfer_size` equals 12 times the number of set mask bits. It holds that value until the next accepted `start`.
- R5: Without predecrement, register i is selected by mask bit 7−i. Registers are visited in ascending index order, and the k-th visited register (counting from 0) uses the slot at `base_addr` + 12k.
- R6: On a store with `predec`=1, register i is selected by mask bit i and registers are visited in descending index order. A pointer starts at `base_addr` + 12×count and drops by 12 before each slot, so the first slot visited is the highest one. On loads `predec` is ignored and R5 applies.
- R7: Each slot is three beats at slot+0, slot+4 and slot+8. On a store these beats carry {sign/exponent, 16'h0000}, then mantissa bits 63:32, then mantissa bits 31:0.
- R8: On a load, `rf_we` pulses once per register after that register's third acknowledge. `rf_wdata` is then {bits 31:16 of beat 0, beat 1, beat 2}, so the pad half of beat 0 is ignored.
- R9: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`. Each acknowledge completes exactly one beat.
- R10: An empty mask makes `done` pulse in the cycle after `start`, with `xfer_size`=0 and no memory request.
- R11: `done` is a one-cycle pulse that comes after the last register's final beat (and its register write, on a load). `busy` is low in the cycle `done` is high.
- R12: A `start` while `busy` is high, and any change of the command inputs during a transfer, has no effect on the running transfer and raises neither `err` nor an extra transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| store | input | 1 | 1: register file to memory, 0: memory to register file |
| predec | input | 1 | Predecrement addressing (stores only) |
| mode | input | 2 | Mask-source mode field |
| cmd_mask | input | NREG | Mask taken from the command word |
| dyn_mask | input | NREG | Mask taken from the selected data register |
| base_addr | input | AW | Base byte address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle invalid-mode pulse |
| xfer_size | output | SZW | Total bytes covered (12 per register) |
| rf_idx | output | IW | Register file index being accessed |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 80 | Register file write value |
| rf_rdata | input | 80 | Register file read value at `rf_idx` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | AW | Memory beat byte address |
| mem_wdata | output | 32 | Memory beat write data |
| mem_rdata | input | 32 | Memory beat read data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat acknowledge |

## Verification
The assertions assume that `mem_ack` is a single-cycle pulse and is raised only while `mem_req` is high. They also assume that `rf_rdata` follows `rf_idx` combinationally and stays steady for as long as the index is held. The bench's memory model acknowledges only a request that is pending, after a latency that varies from 0 to 2 cycles, and drops `mem_ack` on the next cycle. Its register-file model reads combinationally. Bases are chosen so that every slot stays inside the modelled memory, and one scenario deliberately changes the command inputs and pulses `start` in the middle of a transfer.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int SLOT_BYTES = 12;
  localparam int BEAT_BYTES = 4;
  localparam int BEATS      = 3;
  localparam int EXP_W      = 16;
  localparam int MANT_W     = 64;
  localparam int FPR_W      = EXP_W + MANT_W;
  localparam int WORD_W     = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_LAUNCH,
    S_BEAT,
    S_NEXT
  } fmm_state_e;
endpackage

// File: rtl/fmm_mask_sel.sv
// Decodes direction and mode into a validity flag, a walk direction,
// a per-register visit vector and the register count.
module fmm_mask_sel #(
  parameter int NREG = 8,
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic            store,
  input  logic            predec,
  input  logic [1:0]      mode,
  input  logic [NREG-1:0] cmd_mask,
  input  logic [NREG-1:0] dyn_mask,
  output logic            bad,
  output logic            walk_down,
  output logic [NREG-1:0] visit,
  output logic [CW-1:0]   count
);
  logic            use_dyn;
  logic [NREG-1:0] mask;

  // loads: only mode 2 (static) and 3 (dynamic) are legal
  // stores: mode bit 0 picks the dynamic source
  assign use_dyn   = store ? mode[0] : (mode == 2'd3);
  assign bad       = !store && !mode[1];
  assign walk_down = store && predec;
  assign mask      = use_dyn ? dyn_mask : cmd_mask;

  // bit polarity depends on the walk direction
  for (genvar g = 0; g < NREG; g++) begin : g_visit
    assign visit[g] = walk_down ? mask[g] : mask[NREG-1-g];
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CW'(visit[i]);
    end
  end
endmodule

// File: rtl/fmm_pick.sv
// Chooses the next register still pending: lowest index when walking up,
// highest index when walking down.
module fmm_pick #(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] pend,
  input  logic            down,
  output logic [IW-1:0]   idx,
  output logic            any
);
  always_comb begin
    idx = '0;
    any = |pend;
    if (down) begin
      for (int i = 0; i < NREG; i++) begin
        if (pend[i]) idx = IW'(i);
      end
    end else begin
      for (int i = NREG - 1; i >= 0; i--) begin
        if (pend[i]) idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fmm_slot_pack.sv
// Slices an extended value into the word for a given beat of its slot.
module fmm_slot_pack
  import fmm_pkg::*;
(
  input  logic [FPR_W-1:0]  fpr,
  input  logic [1:0]        beat,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    case (beat)
      2'd0:    word = {fpr[FPR_W-1 -: EXP_W], 16'h0000};
      2'd1:    word = fpr[MANT_W-1 -: WORD_W];
      default: word = fpr[WORD_W-1:0];
    endcase
  end
endmodule

// File: rtl/fmm_seq.sv
module fmm_seq
  import fmm_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1),
  localparam int SZW = $clog2(SLOT_BYTES * NREG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              store,
  input  logic              predec,
  input  logic [1:0]        mode,
  input  logic [NREG-1:0]   cmd_mask,
  input  logic [NREG-1:0]   dyn_mask,
  input  logic [AW-1:0]     base_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [SZW-1:0]    xfer_size,
  output logic [IW-1:0]     rf_idx,
  output logic              rf_we,
  output logic [FPR_W-1:0]  rf_wdata,
  input  logic [FPR_W-1:0]  rf_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  fmm_state_e        state;
  logic [NREG-1:0]   pend;
  logic              down_r;
  logic              store_r;
  logic [AW-1:0]     slot_ptr;
  logic [AW-1:0]     slot_base;
  logic [1:0]        beat;
  logic [EXP_W-1:0]  cap_exp;
  logic [WORD_W-1:0] cap_hi;

  logic              sel_bad;
  logic              sel_down;
  logic [NREG-1:0]   sel_visit;
  logic [CW-1:0]     sel_count;
  logic [IW-1:0]     pk_idx;
  logic              pk_any;
  logic [1:0]        pack_beat;
  logic [WORD_W-1:0] pack_word;

  fmm_mask_sel #(.NREG(NREG)) u_mask (
    .store     (store),
    .predec    (predec),
    .mode      (mode),
    .cmd_mask  (cmd_mask),
    .dyn_mask  (dyn_mask),
    .bad       (sel_bad),
    .walk_down (sel_down),
    .visit     (sel_visit),
    .count     (sel_count)
  );

  fmm_pick #(.NREG(NREG)) u_pick (
    .pend (pend),
    .down (down_r),
    .idx  (pk_idx),
    .any  (pk_any)
  );

  // beat being loaded into the output register next
  assign pack_beat = (state == S_BEAT) ? beat + 2'd1 : 2'd0;

  fmm_slot_pack u_pack (
    .fpr  (rf_rdata),
    .beat (pack_beat),
    .word (pack_word)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pend      <= '0;
      down_r    <= 1'b0;
      store_r   <= 1'b0;
      slot_ptr  <= '0;
      slot_base <= '0;
      beat      <= '0;
      cap_exp   <= '0;
      cap_hi    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      xfer_size <= '0;
      rf_idx    <= '0;
      rf_we     <= 1'b0;
      rf_wdata  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      rf_we <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (sel_bad) begin
              xfer_size <= '0;
              err       <= 1'b1;
            end else begin
              xfer_size <= SZW'(sel_count * SLOT_BYTES);
              if (sel_count == '0) begin
                done <= 1'b1;
              end else begin
                pend     <= sel_visit;
                down_r   <= sel_down;
                store_r  <= store;
                slot_ptr <= sel_down ? base_addr + AW'(sel_count * SLOT_BYTES)
                                     : base_addr;
                state    <= S_SETUP;
              end
            end
          end
        end
        S_SETUP: begin
          rf_idx       <= pk_idx;
          pend[pk_idx] <= 1'b0;
          if (down_r) begin
            // predecrement: step down before using the slot
            slot_base <= slot_ptr - AW'(SLOT_BYTES);
            slot_ptr  <= slot_ptr - AW'(SLOT_BYTES);
          end else begin
            slot_base <= slot_ptr;
            slot_ptr  <= slot_ptr + AW'(SLOT_BYTES);
          end
          state <= S_LAUNCH;
        end
        S_LAUNCH: begin
          mem_req   <= 1'b1;
          mem_we    <= store_r;
          mem_addr  <= slot_base;
          beat      <= 2'd0;
          mem_wdata <= store_r ? pack_word : '0;
          state     <= S_BEAT;
        end
        S_BEAT: begin
          if (mem_ack) begin
            if (beat == 2'd0) cap_exp <= mem_rdata[WORD_W-1 -: EXP_W];
            if (beat == 2'd1) cap_hi  <= mem_rdata;
            if (beat == 2'(BEATS - 1)) begin
              mem_req  <= 1'b0;
              mem_we   <= 1'b0;
              rf_we    <= !store_r;
              rf_wdata <= {cap_exp, cap_hi, mem_rdata};
              state    <= S_NEXT;
            end else begin
              beat      <= beat + 2'd1;
              mem_addr  <= mem_addr + AW'(BEAT_BYTES);
              mem_wdata <= store_r ? pack_word : '0;
            end
          end
        end
        S_NEXT: begin
          if (pk_any) begin
            state <= S_SETUP;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fmm_seq_chk.sv
module fmm_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          rf_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [1:0]    beat
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && beat != 2'd2 |=> mem_req && mem_addr == $past(mem_addr) + AW'(4)); // R7

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && beat == 2'd0 |-> mem_wdata[15:0] == 16'h0000); // R7

  AST_RF_WE_OUTSIDE_BEAT: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !mem_req && !mem_we); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !mem_req); // R11

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> !done && !busy && !mem_req); // R2

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !rf_we); // R12
endmodule

bind fmm_seq fmm_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .rf_we     (rf_we),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .beat      (beat)
);

// File: tb/fmm_seq_tb.sv
module fmm_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        store = 1'b0;
  logic        predec = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  cmd_mask = 8'h00;
  logic [7:0]  dyn_mask = 8'h00;
  logic [31:0] base_addr = 32'h0;
  logic        busy, done, err;
  logic [6:0]  xfer_size;
  logic [2:0]  rf_idx;
  logic        rf_we;
  logic [79:0] rf_wdata;
  logic [79:0] rf_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'h0;
  logic        mem_ack = 1'b0;

  int total = 0;
  int passed = 0;

  logic [79:0] rf [0:7];
  logic [31:0] mem [0:63];
  logic [31:0] beat_log [0:511];
  int          beat_n = 0;
  logic [2:0]  rf_log [0:511];
  int          rf_n = 0;
  int          req_seen = 0;
  int          lat_seed = 0;
  int          lat_cnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fmm_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .store(store), .predec(predec),
    .mode(mode), .cmd_mask(cmd_mask), .dyn_mask(dyn_mask), .base_addr(base_addr),
    .busy(busy), .done(done), .err(err), .xfer_size(xfer_size),
    .rf_idx(rf_idx), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign rf_rdata = rf[rf_idx];

  always @(posedge clk) begin
    if (rf_we) begin
      rf[rf_idx]     <= rf_wdata;
      rf_log[rf_n]   <= rf_idx;
      rf_n           <= rf_n + 1;
    end
  end

  // memory model: one-cycle ack after a latency of 0..2 cycles
  always @(negedge clk) begin
    if (mem_req) req_seen = req_seen + 1;
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat_cnt != 0) begin
        lat_cnt = lat_cnt - 1;
      end else begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[7:2]];
        beat_log[beat_n] = mem_addr;
        beat_n   = beat_n + 1;
        lat_seed = lat_seed + 1;
        lat_cnt  = lat_seed % 3;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | (i * 32'h0001_0101) | 32'h0000_0F0F;
  endtask

  // One transfer with independent expectations; poke disturbs inputs mid-run.
  task automatic run(input string tag, input logic st, input logic pd, input logic [1:0] md,
                     input logic [7:0] cm, input logic [7:0] dm, input logic [31:0] ba,
                     input bit poke);
    logic [7:0]  m;
    bit          down, bad;
    int          cnt, k, n, b0, r0, q0;
    logic [31:0] a;
    logic [31:0] eaddr [0:7];
    logic [2:0]  ereg [0:7];
    logic [79:0] rf_snap [0:7];
    bit          got, e_seen, ok;
    logic [6:0]  sz;

    bad  = !st && !md[1];
    m    = (st ? md[0] : (md == 2'd3)) ? dm : cm;
    down = st && pd;
    cnt  = $countones(m);
    k = 0;
    if (!down) begin
      for (int i = 0; i < 8; i++) if (m[7-i]) begin ereg[k] = 3'(i); eaddr[k] = ba + 32'(12 * k); k++; end
    end else begin
      a = ba + 32'(12 * cnt);
      for (int i = 7; i >= 0; i--) if (m[i]) begin a = a - 32'd12; ereg[k] = 3'(i); eaddr[k] = a; k++; end
    end
    for (int i = 0; i < 8; i++) rf_snap[i] = rf[i];
    b0 = beat_n; r0 = rf_n; q0 = req_seen;

    store = st; predec = pd; mode = md; cmd_mask = cm; dyn_mask = dm; base_addr = ba;
    start = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    sz     = xfer_size;
    e_seen = err;
    got    = done || err;
    if (bad) begin
      chk(err == 1'b1 && done == 1'b0, {tag, " R2 err pulse"}, {78'd0, done, err}, 80'd1);
      chk(sz == 7'd0, {tag, " R2 size zero"}, 80'(sz), 80'd0);
    end else if (cnt == 0) begin
      chk(done == 1'b1 && busy == 1'b0, {tag, " R10 immediate done"}, {78'd0, busy, done}, 80'd1);
      chk(sz == 7'd0, {tag, " R10 size zero"}, 80'(sz), 80'd0);
    end else begin
      chk(sz == 7'(12 * cnt), {tag, " R4 size"}, 80'(sz), 80'(12 * cnt));
    end
    n = 0;
    while (!got && n < 3000) begin
      if (poke && n == 3) begin
        store = 1'b0; mode = 2'd0; cmd_mask = 8'h00; dyn_mask = 8'h00; base_addr = 32'h80;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
      if (err) e_seen = 1'b1;
      got = done || err;
    end
    start = 1'b0;
    if (!bad) begin
      chk(done && !busy && !e_seen, {tag, " R11 done with busy low"}, {77'd0, e_seen, busy, done}, 80'd1);
      chk(xfer_size == sz, {tag, " R4 size held"}, 80'(xfer_size), 80'(sz));
    end
    @(negedge clk);
    chk(!done && !err, {tag, " R11 done one cycle"}, {78'd0, err, done}, 80'd0);
    repeat (4) @(negedge clk);

    if (bad || cnt == 0) begin
      chk(req_seen == q0, {tag, " R2 R10 no memory request"}, 80'(req_seen - q0), 80'd0);
      ok = 1'b1;
      for (int i = 0; i < 8; i++) if (rf[i] !== rf_snap[i]) ok = 1'b0;
      chk(ok && rf_n == r0, {tag, " R2 register file untouched"}, 80'(rf_n - r0), 80'd0);
    end else begin
      chk(beat_n - b0 == 3 * k, {tag, " R9 beat count"}, 80'(beat_n - b0), 80'(3 * k));
      ok = 1'b1;
      for (int j = 0; j < k; j++)
        for (int t = 0; t < 3; t++)
          if (beat_log[b0 + 3*j + t] !== eaddr[j] + 32'(4 * t)) begin
            if (ok) chk(1'b0, {tag, (down ? " R6" : " R5"), " R7 beat address order"},
                        80'(beat_log[b0 + 3*j + t]), 80'(eaddr[j] + 32'(4 * t)));
            ok = 1'b0;
          end
      if (ok) chk(1'b1, {tag, " R5 R6 order"}, 80'd0, 80'd0);
      if (st) begin
        ok = 1'b1;
        for (int j = 0; j < k; j++) begin
          if (mem[eaddr[j][7:2]]     !== {rf[ereg[j]][79:64], 16'h0000} ||
              mem[eaddr[j][7:2] + 1] !== rf[ereg[j]][63:32] ||
              mem[eaddr[j][7:2] + 2] !== rf[ereg[j]][31:0]) begin
            if (ok) chk(1'b0, {tag, " R7 store slot layout"}, {48'd0, mem[eaddr[j][7:2]]},
                        {48'd0, rf[ereg[j]][79:64], 16'h0000});
            ok = 1'b0;
          end
        end
        if (ok) chk(1'b1, {tag, " R7 store slot layout"}, 80'd0, 80'd0);
        chk(rf_n == r0, {tag, " R7 store does not write registers"}, 80'(rf_n - r0), 80'd0);
      end else begin
        chk(rf_n - r0 == k, {tag, " R8 one write per register"}, 80'(rf_n - r0), 80'(k));
        ok = 1'b1;
        for (int j = 0; j < k; j++) begin
          if (rf_log[r0 + j] !== ereg[j] ||
              rf[ereg[j]] !== {mem[eaddr[j][7:2]][31:16], mem[eaddr[j][7:2] + 1], mem[eaddr[j][7:2] + 2]}) begin
            if (ok) chk(1'b0, {tag, " R8 load value"}, rf[ereg[j]],
                        {mem[eaddr[j][7:2]][31:16], mem[eaddr[j][7:2] + 1], mem[eaddr[j][7:2] + 2]});
            ok = 1'b0;
          end
        end
        if (ok) chk(1'b1, {tag, " R8 load value"}, 80'd0, 80'd0);
        for (int i = 0; i < 8; i++) begin
          bit hit = 1'b0;
          for (int j = 0; j < k; j++) if (ereg[j] == 3'(i)) hit = 1'b1;
          if (!hit && rf[i] !== rf_snap[i]) chk(1'b0, {tag, " R3 unselected register changed"}, rf[i], rf_snap[i]);
        end
      end
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !mem_req && !mem_we && !rf_we && xfer_size == 7'd0,
        "R1 reset state", {73'd0, busy, done, err, mem_req, mem_we, rf_we, 1'b0},
        80'd0);
  endtask

  task automatic t_store_static();
    fill_mem();
    run("store mode0 up", 1'b1, 1'b0, 2'd0, 8'b1010_0110, 8'hFF, 32'd8, 1'b0);
    chk(mem[(8 + 48) / 4] == (32'hC0DE_0F0F | (14 * 32'h0001_0101)), "R5 word past region untouched",
        80'(mem[14]), 80'(32'hC0DE_0F0F | (14 * 32'h0001_0101)));
  endtask

  task automatic t_store_predec_dyn();
    fill_mem();
    run("store mode1 predec", 1'b1, 1'b1, 2'd1, 8'h00, 8'b1100_1001, 32'd20, 1'b0);
    chk(mem[4] == (32'hC0DE_0F0F | (4 * 32'h0001_0101)), "R6 word below base untouched",
        80'(mem[4]), 80'(32'hC0DE_0F0F | (4 * 32'h0001_0101)));
  endtask

  task automatic t_store_full_predec();
    fill_mem();
    run("store mode3 full predec", 1'b1, 1'b1, 2'd3, 8'h01, 8'hFF, 32'd4, 1'b0);
  endtask

  task automatic t_store_mode2_static();
    fill_mem();
    run("store mode2 static R3", 1'b1, 1'b0, 2'd2, 8'b0000_0011, 8'hF0, 32'd12, 1'b0);
  endtask

  task automatic t_load_static();
    fill_mem();
    run("load mode2 R3", 1'b0, 1'b0, 2'd2, 8'b1001_0001, 8'h7E, 32'd16, 1'b0);
  endtask

  task automatic t_load_dyn_predec_ignored();
    fill_mem();
    run("load mode3 predec ignored R6", 1'b0, 1'b1, 2'd3, 8'hFF, 8'b0110_1010, 32'd40, 1'b0);
  endtask

  task automatic t_load_bad();
    run("load mode0", 1'b0, 1'b0, 2'd0, 8'hFF, 8'hFF, 32'd0, 1'b0);
    run("load mode1", 1'b0, 1'b0, 2'd1, 8'h0F, 8'hF0, 32'd0, 1'b0);
  endtask

  task automatic t_empty();
    run("store empty", 1'b1, 1'b1, 2'd0, 8'h00, 8'hFF, 32'd24, 1'b0);
    run("load empty", 1'b0, 1'b0, 2'd3, 8'hFF, 8'h00, 32'd24, 1'b0);
  endtask

  task automatic t_busy_start();
    fill_mem();
    run("store R12 start while busy", 1'b1, 1'b0, 2'd0, 8'b0111_0000, 8'h00, 32'd0, 1'b1);
    fill_mem();
    run("load R12 start while busy", 1'b0, 1'b0, 2'd2, 8'b0000_1110, 8'h00, 32'd36, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++)
      rf[i] = {16'h4000 + 16'(i), 32'h8000_0000 | (32'(i) << 8), 32'h1234_0000 + 32'(i)};
    fill_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_store_static();
    t_store_predec_dyn();
    t_store_full_predec();
    t_store_mode2_static();
    t_load_static();
    t_load_dyn_predec_ignored();
    t_load_bad();
    t_empty();
    t_busy_start();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule